// File: doc/BRIEF.md
# Cascaded Capture Timer

This block joins two equal counter halves into one wide free-running timer with input capture. The low half advances on every clock while the timer is running. When the low half rolls over, a carry is registered and the high half advances on the following clock. The carry therefore lands one cycle late, and for one cycle the full count shows the new low value beside the old high value.

A capture trigger comes from an external event line or from a software strobe; either one fires it. The trigger copies both halves into a capture register of full width and raises a capture flag. A delay select decides when the high half takes its copy. In the same-edge mode both halves copy on the trigger edge. A trigger in the cycle just after a low rollover then gives a high word that is one too small. In the delayed mode the high half copies one clock later, after the carry has landed, so the captured word is always consistent.

Capture control is a two-state machine. CAP_IDLE waits for a trigger. The transition IDLE_TO_HOLD happens when a trigger arrives with the delay selected, and the low half copies on that edge. CAP_HOLD is the state in which the high half copies. The transition HOLD_TO_HOLD happens when a further delayed trigger arrives during CAP_HOLD. The transition HOLD_TO_IDLE happens otherwise. The transition IDLE_TO_IDLE covers an idle cycle and also a same-edge capture.

Top module: `cascade_capture_timer`

## Requirements
- R1: While `rst_n` is low, `count`, `cap_val` and `cap_flag` are all zero.
- R2: When `clk_sel` is 0 the low half holds its value. When `clk_sel` is any nonzero value, the low half advances by one on every rising clock edge.
- R3: The low half rolls over from all ones to zero. Its internal wrap pulse lasts exactly one cycle.
- R4: The high half advances one clock after the low rollover. In the cycle right after the rollover, `count` shows the old high half beside a low half of zero.
- R5: A capture trigger is `cap_evt` OR `sw_strobe`, sampled on a rising edge. On that edge the low half of `cap_val` takes the low count present before the edge.
- R6: With `evt_dly_en` at 0, the high half of `cap_val` copies on the trigger edge. A trigger in the cycle right after a low rollover therefore captures the old high value, which is one less than the true high value.
- R7: With `evt_dly_en` at 1, the high half copies one clock after the trigger edge. The result equals the true count at the trigger, including triggers at the all-ones and zero low values. `cap_flag` stays low until the high copy is made.
- R8: `cap_flag` sets on the edge where the high half copies. It clears on an edge where `flag_clr` is 1. A set on the same edge as a clear takes priority.
- R9: With `evt_dly_en` at 1, triggers on two consecutive edges leave `cap_val` equal to the count at the second trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_sel | input | 2 | Count enable select; 0 stops the timer, any other value runs it |
| cap_evt | input | 1 | Capture event line |
| sw_strobe | input | 1 | Software capture strobe |
| evt_dly_en | input | 1 | 1 delays the high-half capture by one clock |
| flag_clr | input | 1 | Write-one-to-clear for the capture flag |
| count | output | 2*HALF_W (32) | Current timer value, high half above low half |
| cap_val | output | 2*HALF_W (32) | Captured timer value |
| cap_flag | output | 1 | Capture complete flag |

## Verification
Counter results and the low capture copy are due one rising edge after the inputs are driven. The high copy and the flag are due on that same edge in the same-edge mode, and one edge later in the delayed mode. The carry into the high half shows two edges after the last all-ones low value. The bench drives every input on a falling edge and reads the outputs on a later falling edge, counting exactly those edges. Rollover cases are reached by waiting at falling edges until the low half reads all ones or zero, then triggering at that moment.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;

    localparam int DEF_HALF_W = 16;
    localparam int SEL_W      = 2;
    localparam int N_HALVES   = 2;

    typedef enum logic [0:0] {
        CAP_IDLE = 1'b0,
        CAP_HOLD = 1'b1
    } cap_state_e;

endpackage

// File: rtl/ctimer_half.sv
module ctimer_half #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         cap_en,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cap
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap <= '0;
        end else if (cap_en) begin
            cap <= cnt;
        end
    end

endmodule

// File: rtl/ctimer_capture.sv
module ctimer_capture
    import ctimer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic dly_en,
    input  logic flag_clr,
    output logic lo_cap_en,
    output logic hi_cap_en,
    output logic flag
);

    cap_state_e state_q;
    cap_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE: begin
                if (trig && dly_en) begin
                    state_d = CAP_HOLD;
                end
            end
            CAP_HOLD: begin
                if (trig && dly_en) begin
                    state_d = CAP_HOLD;
                end else begin
                    state_d = CAP_IDLE;
                end
            end
            default: state_d = CAP_IDLE;
        endcase
    end

    always_comb begin
        lo_cap_en = trig;
        hi_cap_en = 1'b0;
        unique case (state_q)
            CAP_IDLE: hi_cap_en = trig && !dly_en;
            CAP_HOLD: hi_cap_en = 1'b1;
            default:  hi_cap_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hi_cap_en) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/cascade_capture_timer.sv
module cascade_capture_timer
    import ctimer_pkg::*;
#(
    parameter int HALF_W = DEF_HALF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SEL_W-1:0]      clk_sel,
    input  logic                  cap_evt,
    input  logic                  sw_strobe,
    input  logic                  evt_dly_en,
    input  logic                  flag_clr,
    output logic [2*HALF_W-1:0]   count,
    output logic [2*HALF_W-1:0]   cap_val,
    output logic                  cap_flag
);

    localparam logic [HALF_W-1:0] LO_TOP = '1;

    logic              run;
    logic              trig;
    logic              lo_wrap;
    logic              carry_q;
    logic              lo_cap_en;
    logic              hi_cap_en;
    logic [HALF_W-1:0] cnt_lo;
    logic [HALF_W-1:0] cnt_hi;
    logic [HALF_W-1:0] cap_lo;
    logic [HALF_W-1:0] cap_hi;

    logic [N_HALVES-1:0] half_inc;
    logic [N_HALVES-1:0] half_cap_en;
    logic [HALF_W-1:0]   half_cnt [N_HALVES];
    logic [HALF_W-1:0]   half_cap [N_HALVES];

    assign run     = |clk_sel;
    assign trig    = cap_evt | sw_strobe;
    assign lo_wrap = run && (cnt_lo == LO_TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else begin
            carry_q <= lo_wrap;
        end
    end

    assign half_inc    = {carry_q, run};
    assign half_cap_en = {hi_cap_en, lo_cap_en};

    for (genvar g = 0; g < N_HALVES; g++) begin : g_half
        ctimer_half #(
            .W (HALF_W)
        ) u_half (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (half_inc[g]),
            .cap_en (half_cap_en[g]),
            .cnt    (half_cnt[g]),
            .cap    (half_cap[g])
        );
    end

    assign cnt_lo = half_cnt[0];
    assign cnt_hi = half_cnt[1];
    assign cap_lo = half_cap[0];
    assign cap_hi = half_cap[1];

    ctimer_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .dly_en    (evt_dly_en),
        .flag_clr  (flag_clr),
        .lo_cap_en (lo_cap_en),
        .hi_cap_en (hi_cap_en),
        .flag      (cap_flag)
    );

    assign count   = {cnt_hi, cnt_lo};
    assign cap_val = {cap_hi, cap_lo};

endmodule

// File: rtl/ctimer_checker.sv
module ctimer_checker #(
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        clk_sel,
    input logic              trig,
    input logic              evt_dly_en,
    input logic              lo_wrap,
    input logic [HALF_W-1:0] cnt_lo,
    input logic [HALF_W-1:0] cnt_hi,
    input logic [HALF_W-1:0] cap_lo,
    input logic              hi_cap_en,
    input logic              cap_flag
);

    localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 2'b00) |=> (cnt_lo == $past(cnt_lo)));

    a_r3_wrap_single: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wrap |=> !lo_wrap);

    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wrap |=> (cnt_lo == '0));

    a_r4_hi_waits: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wrap |=> (cnt_hi == $past(cnt_hi)));

    a_r4_hi_steps: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lo_wrap, 2) |-> (cnt_hi == $past(cnt_hi) + ONE));

    a_r5_lo_copy: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cap_lo == $past(cnt_lo)));

    a_r6_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !evt_dly_en) |-> hi_cap_en);

    a_r7_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && evt_dly_en) |=> hi_cap_en);

    a_r8_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cap_en |=> cap_flag);

endmodule

bind cascade_capture_timer ctimer_checker #(
    .HALF_W (HALF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_sel    (clk_sel),
    .trig       (trig),
    .evt_dly_en (evt_dly_en),
    .lo_wrap    (lo_wrap),
    .cnt_lo     (cnt_lo),
    .cnt_hi     (cnt_hi),
    .cap_lo     (cap_lo),
    .hi_cap_en  (hi_cap_en),
    .cap_flag   (cap_flag)
);

// File: tb/sim_cascade_capture_timer.sv
module sim_cascade_capture_timer;

    localparam int HW = 8;
    localparam int FW = 2 * HW;
    localparam logic [HW-1:0] LO_MAX = '1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    clk_sel;
    logic          cap_evt;
    logic          sw_strobe;
    logic          evt_dly_en;
    logic          flag_clr;
    logic [FW-1:0] count;
    logic [FW-1:0] cap_val;
    logic          cap_flag;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cascade_capture_timer #(
        .HALF_W (HW)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_sel    (clk_sel),
        .cap_evt    (cap_evt),
        .sw_strobe  (sw_strobe),
        .evt_dly_en (evt_dly_en),
        .flag_clr   (flag_clr),
        .count      (count),
        .cap_val    (cap_val),
        .cap_flag   (cap_flag)
    );

    task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic wait_lo(input logic [HW-1:0] v);
        while (count[HW-1:0] !== v) @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 count in reset", count, '0);
        chk("R1 cap_val in reset", cap_val, '0);
        chk("R1 flag in reset", FW'(cap_flag), '0);
        rst_n = 1'b1;
    endtask

    task automatic t_stopped();
        repeat (6) @(negedge clk);
        chk("R2 count held at select 0", count, '0);
    endtask

    task automatic t_counting();
        logic [FW-1:0] c0;
        clk_sel = 2'b01;
        c0 = count;
        repeat (10) @(negedge clk);
        chk("R2 count advances with select 1", count, c0 + FW'(10));
        clk_sel = 2'b11;
        c0 = count;
        repeat (5) @(negedge clk);
        chk("R2 count advances with select 3", count, c0 + FW'(5));
        clk_sel = 2'b00;
        c0 = count;
        repeat (4) @(negedge clk);
        chk("R2 count held after stop", count, c0);
        clk_sel = 2'b01;
    endtask

    task automatic t_capture_plain();
        logic [FW-1:0] c;
        evt_dly_en = 1'b0;
        wait_lo(8'h10);
        c = count;
        cap_evt = 1'b1;
        @(negedge clk);
        cap_evt = 1'b0;
        chk("R5 R6 same-edge capture", cap_val, c);
        chk("R8 flag after capture", FW'(cap_flag), FW'(1));
    endtask

    task automatic t_flag();
        clear_flag();
        chk("R8 flag cleared", FW'(cap_flag), '0);
        evt_dly_en = 1'b0;
        cap_evt    = 1'b1;
        flag_clr   = 1'b1;
        @(negedge clk);
        cap_evt  = 1'b0;
        flag_clr = 1'b0;
        chk("R8 set wins over clear", FW'(cap_flag), FW'(1));
        clear_flag();
    endtask

    task automatic t_strobe_delayed();
        logic [FW-1:0] c;
        evt_dly_en = 1'b1;
        wait_lo(8'h20);
        c = count;
        sw_strobe = 1'b1;
        @(negedge clk);
        sw_strobe = 1'b0;
        chk("R5 strobe low copy", FW'(cap_val[HW-1:0]), FW'(c[HW-1:0]));
        chk("R7 flag low before high copy", FW'(cap_flag), '0);
        @(negedge clk);
        chk("R7 delayed strobe capture", cap_val, c);
        chk("R7 flag after high copy", FW'(cap_flag), FW'(1));
        clear_flag();
    endtask

    task automatic t_wrap();
        logic [HW-1:0] h;
        wait_lo(LO_MAX);
        h = count[FW-1:HW];
        @(negedge clk);
        chk("R3 low rolls to zero", FW'(count[HW-1:0]), '0);
        chk("R4 high unchanged right after roll", FW'(count[FW-1:HW]), FW'(h));
        @(negedge clk);
        chk("R4 high advanced one clock later", count, {h + HW'(1), HW'(1)});
    endtask

    task automatic t_torn();
        logic [HW-1:0] h;
        evt_dly_en = 1'b0;
        wait_lo(LO_MAX);
        @(negedge clk);
        h = count[FW-1:HW];
        cap_evt = 1'b1;
        @(negedge clk);
        cap_evt = 1'b0;
        chk("R6 torn capture keeps old high", cap_val, {h, HW'(0)});
        chk("R4 true high is one more", FW'(count[FW-1:HW]), FW'(h + HW'(1)));
        clear_flag();
    endtask

    task automatic t_fixed_zero();
        logic [HW-1:0] h;
        evt_dly_en = 1'b1;
        wait_lo(LO_MAX);
        @(negedge clk);
        h = count[FW-1:HW];
        cap_evt = 1'b1;
        @(negedge clk);
        cap_evt = 1'b0;
        @(negedge clk);
        chk("R7 delayed capture after roll", cap_val, {h + HW'(1), HW'(0)});
        clear_flag();
    endtask

    task automatic t_fixed_max();
        logic [HW-1:0] h;
        evt_dly_en = 1'b1;
        wait_lo(LO_MAX);
        h = count[FW-1:HW];
        cap_evt = 1'b1;
        @(negedge clk);
        cap_evt = 1'b0;
        @(negedge clk);
        chk("R7 delayed capture at all ones", cap_val, {h, LO_MAX});
        clear_flag();
    endtask

    task automatic t_back_to_back();
        logic [FW-1:0] c2;
        evt_dly_en = 1'b1;
        wait_lo(8'h40);
        cap_evt = 1'b1;
        @(negedge clk);
        c2 = count;
        @(negedge clk);
        cap_evt = 1'b0;
        @(negedge clk);
        chk("R9 second trigger wins", cap_val, c2);
        chk("R9 flag set", FW'(cap_flag), FW'(1));
        clear_flag();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst_n      = 1'b0;
        clk_sel    = 2'b00;
        cap_evt    = 1'b0;
        sw_strobe  = 1'b0;
        evt_dly_en = 1'b0;
        flag_clr   = 1'b0;
        t_reset();
        t_stopped();
        t_counting();
        t_capture_plain();
        t_flag();
        t_strobe_delayed();
        t_wrap();
        t_torn();
        t_fixed_zero();
        t_fixed_max();
        t_back_to_back();
        report();
    end

endmodule